// File: doc/BRIEF.md
# I2C Master Byte Transfer Engine

This block moves one byte at a time between a CPU-side buffer register and an I2C bus, acting as the master. A write into the buffer while the engine is idle starts a transmit. The byte leaves on SDA most significant bit first. SDA is then released for the slave's acknowledge, which is captured into a status bit. Setting the receive request while idle starts a receive instead. Eight bits are sampled on the rising edges of SCL and placed into the buffer.

A programmable reload value paces SCL. Each half of the clock period lasts reload+1 cycles of the system clock. The pacing counter runs only while a byte is in flight. Between bytes SCL is parked low and SDA is released, so the next byte can continue the same bus transaction. Start, stop, master-side acknowledge and arbitration belong to surrounding logic.

Both bus lines are modelled as active-high pull-low enables, where 0 lets the pull-up bring the line to 1. The level on SDA is read back on its own input. Status covers buffer full, write collision, receive overflow, acknowledge status and a byte-complete interrupt flag. Each sticky flag has its own clear strobe.

Top module: `i2c_byte_engine`

## Requirements
- R1: After reset, scl_pull, sda_pull, buf_full, wr_coll, rx_ovf, ack_nack, irq and rx_busy are 0, and buf_rdata is 0.
- R2: A buf_we while idle loads buf_wdata, sets buf_full on the next cycle and starts a transmit. The 8 data bits appear on SDA most significant first, each stable across the SCL high phase, and SDA changes only while SCL is low.
- R3: While a byte is in flight, every SCL high phase lasts exactly reload+1 clock cycles.
- R4: At the eighth falling SCL edge of a transmit, buf_full clears and sda_pull drops to 0, releasing SDA for the acknowledge slot.
- R5: SDA is sampled at the ninth falling SCL edge of a transmit. ack_nack becomes 0 if the line was low (ACK) and 1 if it was high (NACK).
- R6: When a byte ends, irq is set, scl_pull stays 1 and sda_pull stays 0. SCL makes no further transitions until the next command.
- R7: A buf_we while a byte is in flight sets wr_coll and leaves the buffer contents unchanged. wr_coll holds until wr_coll_clr.
- R8: An rx_req while idle sets rx_busy and starts a receive, sampling SDA on each rising SCL edge, most significant bit first. At the eighth falling edge, rx_busy clears, the byte is placed in the buffer, and buf_full and irq are set.
- R9: A buf_re strobe clears buf_full, unless a received byte completes in the same cycle.
- R10: A receive that completes while buf_full is set and no buf_re is present sets rx_ovf and leaves the buffer unchanged. rx_ovf holds until rx_ovf_clr.
- R11: rx_req is ignored while a byte is in flight, and also in a cycle where buf_we starts a transmit. rx_busy stays 0.
- R12: irq stays set until irq_clr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reload | input | CW | Half-period reload value for SCL pacing |
| buf_we | input | 1 | CPU write strobe for the buffer |
| buf_wdata | input | DW | Byte written by the CPU |
| buf_re | input | 1 | CPU read strobe for the buffer |
| buf_rdata | output | DW | Current buffer contents |
| rx_req | input | 1 | Request to receive one byte |
| rx_busy | output | 1 | Receive enable, self-clearing at byte end |
| wr_coll_clr | input | 1 | Clears the write-collision flag |
| rx_ovf_clr | input | 1 | Clears the overflow flag |
| irq_clr | input | 1 | Clears the interrupt flag |
| buf_full | output | 1 | Buffer full flag |
| wr_coll | output | 1 | Write collision flag |
| rx_ovf | output | 1 | Receive overflow flag |
| ack_nack | output | 1 | Acknowledge status, 1 = NACK |
| irq | output | 1 | Byte complete interrupt flag |
| scl_pull | output | 1 | Pull SCL low when 1 |
| sda_pull | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Level read back from the SDA pad |

## Verification
The assertions assume that SCL is never held low by another device, so each half period is set by the pacing counter alone. They also assume that reload is left unchanged while a byte is in flight. The bench writes reload only while the engine is idle. Its slave model drives SDA only in the cycles after it has seen SCL fall, and never drives SCL. The model releases SDA after the acknowledge slot, so the sampled levels always come from the bit the requirement names.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_TX   = 2'd1,
    ENG_RX   = 2'd2
  } eng_mode_e;
endpackage

// File: rtl/i2c_rate_gen.sv
module i2c_rate_gen #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] reload,
  output logic          tick
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)                cnt_d = reload;
    else if (cnt_q == '0)    cnt_d = reload;
    else                     cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run && (cnt_q == '0);

  // R3: once a tick fires with a nonzero reload, the next cycle cannot tick
  a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && reload != '0) |=> !tick);
endmodule

// File: rtl/i2c_bit_seq.sv
module i2c_bit_seq
  import i2c_eng_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start_tx,
  input  logic          start_rx,
  input  logic [DW-1:0] tx_byte,
  input  logic          sda_in,
  output eng_mode_e     mode,
  output logic          scl_pull,
  output logic          sda_pull,
  output logic [DW-1:0] rx_byte,
  output logic          tx_last8,
  output logic          byte_done,
  output logic          ack_level
);
  localparam int BCW = $clog2(DW + 1);
  localparam logic [BCW-1:0] LAST_TX = BCW'(DW);
  localparam logic [BCW-1:0] LAST_RX = BCW'(DW - 1);

  eng_mode_e      mode_q, mode_d;
  logic           hi_q, hi_d;
  logic           park_q, park_d;
  logic [BCW-1:0] bit_q, bit_d;
  logic [DW-1:0]  sh_q, sh_d;
  logic           fall;

  always_comb begin
    mode_d = mode_q;
    hi_d   = hi_q;
    park_d = park_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    unique case (mode_q)
      ENG_IDLE: begin
        if (start_tx) begin
          mode_d = ENG_TX;
          sh_d   = tx_byte;
          bit_d  = '0;
          hi_d   = 1'b0;
        end else if (start_rx) begin
          mode_d = ENG_RX;
          sh_d   = '0;
          bit_d  = '0;
          hi_d   = 1'b0;
        end
      end
      ENG_TX: begin
        if (tick) begin
          if (!hi_q) begin
            hi_d = 1'b1;
          end else begin
            hi_d = 1'b0;
            sh_d = {sh_q[DW-2:0], 1'b0};
            if (bit_q == LAST_TX) begin
              mode_d = ENG_IDLE;
              park_d = 1'b1;
            end else begin
              bit_d = bit_q + BCW'(1);
            end
          end
        end
      end
      ENG_RX: begin
        if (tick) begin
          if (!hi_q) begin
            hi_d = 1'b1;
            sh_d = {sh_q[DW-2:0], sda_in};
          end else begin
            hi_d = 1'b0;
            if (bit_q == LAST_RX) begin
              mode_d = ENG_IDLE;
              park_d = 1'b1;
            end else begin
              bit_d = bit_q + BCW'(1);
            end
          end
        end
      end
      default: mode_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= ENG_IDLE;
      hi_q   <= 1'b0;
      park_q <= 1'b0;
      bit_q  <= '0;
      sh_q   <= '0;
    end else begin
      mode_q <= mode_d;
      hi_q   <= hi_d;
      park_q <= park_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
    end
  end

  assign fall      = tick && hi_q && (mode_q != ENG_IDLE);
  assign tx_last8  = fall && (mode_q == ENG_TX) && (bit_q == LAST_RX);
  assign byte_done = fall && (((mode_q == ENG_TX) && (bit_q == LAST_TX)) ||
                              ((mode_q == ENG_RX) && (bit_q == LAST_RX)));
  assign ack_level = sda_in;
  assign mode      = mode_q;
  assign rx_byte   = sh_q;
  assign scl_pull  = (mode_q == ENG_IDLE) ? park_q : !hi_q;
  assign sda_pull  = (mode_q == ENG_TX) && (bit_q < LAST_TX) && !sh_q[DW-1];

  // R3: the SCL phase only moves on a pacing tick
  a_r3_phase_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(hi_q));
  // R4: acknowledge slot releases SDA
  a_r4_ack_slot_free: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last8 |=> !sda_pull);
  // R6: byte end parks SCL low with SDA free
  a_r6_park_low: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (scl_pull && !sda_pull && mode_q == ENG_IDLE));
  // R11: a receive request during a transmit does not switch modes
  a_r11_rx_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == ENG_TX && start_rx) |=> mode_q != ENG_RX);
endmodule

// File: rtl/i2c_flag_regs.sv
module i2c_flag_regs
  import i2c_eng_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  eng_mode_e     mode,
  input  logic          buf_we,
  input  logic [DW-1:0] buf_wdata,
  input  logic          buf_re,
  input  logic          rx_req,
  input  logic          wr_coll_clr,
  input  logic          rx_ovf_clr,
  input  logic          irq_clr,
  input  logic          tx_last8,
  input  logic          byte_done,
  input  logic [DW-1:0] rx_byte,
  input  logic          ack_level,
  output logic [DW-1:0] buf_q,
  output logic          buf_full,
  output logic          wr_coll,
  output logic          rx_ovf,
  output logic          ack_nack,
  output logic          irq,
  output logic          rx_busy,
  output logic          start_tx,
  output logic          start_rx
);
  logic          idle, rx_done, tx_done, lost;
  logic [DW-1:0] buf_d;
  logic          bf_q, bf_d, wc_q, wc_d, ov_q, ov_d, ak_q, ak_d, iq_q, iq_d, re_q, re_d;

  assign idle     = (mode == ENG_IDLE);
  assign start_tx = idle && buf_we;
  assign start_rx = idle && rx_req && !buf_we;
  assign rx_done  = byte_done && (mode == ENG_RX);
  assign tx_done  = byte_done && (mode == ENG_TX);
  assign lost     = rx_done && bf_q && !buf_re;

  always_comb begin
    buf_d = buf_q;
    if (start_tx)               buf_d = buf_wdata;
    else if (rx_done && !lost)  buf_d = rx_byte;

    bf_d = bf_q;
    if (buf_re)   bf_d = 1'b0;
    if (tx_last8) bf_d = 1'b0;
    if (rx_done)  bf_d = 1'b1;
    if (start_tx) bf_d = 1'b1;

    wc_d = wc_q;
    if (wr_coll_clr)        wc_d = 1'b0;
    if (buf_we && !idle)    wc_d = 1'b1;

    ov_d = ov_q;
    if (rx_ovf_clr) ov_d = 1'b0;
    if (lost)       ov_d = 1'b1;

    ak_d = tx_done ? ack_level : ak_q;

    iq_d = iq_q;
    if (irq_clr)   iq_d = 1'b0;
    if (byte_done) iq_d = 1'b1;

    re_d = re_q;
    if (start_rx) re_d = 1'b1;
    if (rx_done)  re_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      bf_q  <= 1'b0;
      wc_q  <= 1'b0;
      ov_q  <= 1'b0;
      ak_q  <= 1'b0;
      iq_q  <= 1'b0;
      re_q  <= 1'b0;
    end else begin
      buf_q <= buf_d;
      bf_q  <= bf_d;
      wc_q  <= wc_d;
      ov_q  <= ov_d;
      ak_q  <= ak_d;
      iq_q  <= iq_d;
      re_q  <= re_d;
    end
  end

  assign buf_full = bf_q;
  assign wr_coll  = wc_q;
  assign rx_ovf   = ov_q;
  assign ack_nack = ak_q;
  assign irq      = iq_q;
  assign rx_busy  = re_q;

  // R7: collision flag and protected buffer
  a_r7_coll_set: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_we && !idle) |=> wr_coll);
  a_r7_buf_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_we && !idle && !rx_done) |=> $stable(buf_q));
  // R10: overflow keeps the old byte
  a_r10_ovf_keep: assert property (@(posedge clk) disable iff (!rst_n)
    lost |=> (rx_ovf && $stable(buf_q)));
  // R5: acknowledge status follows the line at the ninth fall
  a_r5_ack_capture: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> ack_nack == $past(ack_level));
  // R8: receive enable drops at byte end
  a_r8_rx_drop: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> (!rx_busy && buf_full));
  // R12: interrupt flag is sticky
  a_r12_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_eng_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] reload,
  input  logic          buf_we,
  input  logic [DW-1:0] buf_wdata,
  input  logic          buf_re,
  output logic [DW-1:0] buf_rdata,
  input  logic          rx_req,
  output logic          rx_busy,
  input  logic          wr_coll_clr,
  input  logic          rx_ovf_clr,
  input  logic          irq_clr,
  output logic          buf_full,
  output logic          wr_coll,
  output logic          rx_ovf,
  output logic          ack_nack,
  output logic          irq,
  output logic          scl_pull,
  output logic          sda_pull,
  input  logic          sda_in
);
  eng_mode_e     mode;
  logic          tick, run, start_tx, start_rx, tx_last8, byte_done, ack_level;
  logic [DW-1:0] rx_byte;

  assign run = (mode != ENG_IDLE);

  i2c_rate_gen #(.CW(CW)) u_rate (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .reload (reload),
    .tick   (tick)
  );

  i2c_bit_seq #(.DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .start_tx  (start_tx),
    .start_rx  (start_rx),
    .tx_byte   (buf_wdata),
    .sda_in    (sda_in),
    .mode      (mode),
    .scl_pull  (scl_pull),
    .sda_pull  (sda_pull),
    .rx_byte   (rx_byte),
    .tx_last8  (tx_last8),
    .byte_done (byte_done),
    .ack_level (ack_level)
  );

  i2c_flag_regs #(.DW(DW)) u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .buf_we      (buf_we),
    .buf_wdata   (buf_wdata),
    .buf_re      (buf_re),
    .rx_req      (rx_req),
    .wr_coll_clr (wr_coll_clr),
    .rx_ovf_clr  (rx_ovf_clr),
    .irq_clr     (irq_clr),
    .tx_last8    (tx_last8),
    .byte_done   (byte_done),
    .rx_byte     (rx_byte),
    .ack_level   (ack_level),
    .buf_q       (buf_rdata),
    .buf_full    (buf_full),
    .wr_coll     (wr_coll),
    .rx_ovf      (rx_ovf),
    .ack_nack    (ack_nack),
    .irq         (irq),
    .rx_busy     (rx_busy),
    .start_tx    (start_tx),
    .start_rx    (start_rx)
  );
endmodule

// File: tb/tb_i2c_byte_engine.sv
module tb_i2c_byte_engine;
  localparam int CLK_PER = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reload = '0;
  logic       buf_we = 1'b0, buf_re = 1'b0, rx_req = 1'b0;
  logic [7:0] buf_wdata = '0;
  logic       wr_coll_clr = 1'b0, rx_ovf_clr = 1'b0, irq_clr = 1'b0;
  logic [7:0] buf_rdata;
  logic       rx_busy, buf_full, wr_coll, rx_ovf, ack_nack, irq, scl_pull, sda_pull;
  logic       slv_pull = 1'b0;
  logic       sda_in;

  assign sda_in = !(sda_pull || slv_pull);

  i2c_byte_engine dut (
    .clk(clk), .rst_n(rst_n), .reload(reload), .buf_we(buf_we), .buf_wdata(buf_wdata),
    .buf_re(buf_re), .buf_rdata(buf_rdata), .rx_req(rx_req), .rx_busy(rx_busy),
    .wr_coll_clr(wr_coll_clr), .rx_ovf_clr(rx_ovf_clr), .irq_clr(irq_clr),
    .buf_full(buf_full), .wr_coll(wr_coll), .rx_ovf(rx_ovf), .ack_nack(ack_nack),
    .irq(irq), .scl_pull(scl_pull), .sda_pull(sda_pull), .sda_in(sda_in)
  );

  always #(CLK_PER/2) clk = !clk;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_buf = '0;
  logic       exp_bf = 1'b0;
  logic       exp_ovf = 1'b0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_clr(input int which);
    @(negedge clk);
    case (which)
      0: irq_clr = 1'b1;
      1: wr_coll_clr = 1'b1;
      default: rx_ovf_clr = 1'b1;
    endcase
    @(negedge clk);
    irq_clr = 1'b0; wr_coll_clr = 1'b0; rx_ovf_clr = 1'b0;
  endtask

  function automatic logic exp_ack_stat(input logic slave_acks);
    return !slave_acks;
  endfunction

  // transmit one byte; coll: write during flight; poke: rx_req during flight; both: rx_req with buf_we
  task automatic tx_byte(input logic [7:0] d, input logic ack, input int rl,
                         input logic coll, input logic poke, input logic both);
    logic [7:0] got = '0;
    int rises = 0, falls = 0, hcnt = 0, guard = 0;
    logic prev, line;
    reload = rl[7:0];
    @(negedge clk);
    buf_we = 1'b1; buf_wdata = d; rx_req = both;
    @(negedge clk);
    buf_we = 1'b0; rx_req = 1'b0;
    chk("R2", "buf_full after write", buf_full, 1);
    if (both) chk("R11", "rx_busy with concurrent write", rx_busy, 0);
    exp_buf = d;
    prev = !scl_pull;
    forever begin
      @(negedge clk);
      buf_we = 1'b0; rx_req = 1'b0;
      guard++;
      line = !scl_pull;
      if (line) hcnt++;
      if (line && !prev) begin
        rises++;
        if (rises <= 8) got[8-rises] = sda_in;
        if (rises == 2 && coll) begin buf_we = 1'b1; buf_wdata = ~d; end
        if (rises == 2 && poke) rx_req = 1'b1;
      end
      if (!line && prev) begin
        falls++;
        chk("R3", "SCL high length", hcnt, rl + 1);
        hcnt = 0;
        if (falls == 8) begin
          chk("R4", "buf_full at eighth fall", buf_full, 0);
          chk("R4", "sda_pull in ack slot", sda_pull, 0);
          slv_pull = ack;
        end
        if (falls == 9) slv_pull = 1'b0;
      end
      if (line && prev && rises <= 8)
        if (sda_in != got[8-rises]) chk("R2", "SDA moved while SCL high", 1, 0);
      prev = line;
      if (irq || guard > 4000) break;
    end
    buf_we = 1'b0; rx_req = 1'b0; slv_pull = 1'b0;
    exp_bf = 1'b0;
    chk("R2", "shifted byte", got, d);
    chk("R5", "ack status", ack_nack, exp_ack_stat(ack));
    chk("R6", "irq at end", irq, 1);
    chk("R6", "SCL parked", scl_pull, 1);
    chk("R6", "SDA released", sda_pull, 0);
    repeat (3 * (rl + 1) + 2) begin
      @(negedge clk);
      if (!scl_pull) chk("R6", "SCL toggled while idle", 0, 1);
    end
    chk("R12", "irq held", irq, 1);
    chk("R2", "buffer holds written byte", buf_rdata, d);
    if (coll) chk("R7", "wr_coll after collision", wr_coll, 1);
    if (poke || both) chk("R11", "rx_busy stays low", rx_busy, 0);
    pulse_clr(0);
    chk("R12", "irq cleared", irq, 0);
    if (coll) begin
      pulse_clr(1);
      chk("R7", "wr_coll cleared", wr_coll, 0);
    end
  endtask

  task automatic rx_byte(input logic [7:0] d, input int rl, input logic rd, input logic coll);
    int falls = 0, rises = 0, guard = 0;
    logic prev, line;
    reload = rl[7:0];
    @(negedge clk);
    rx_req = 1'b1;
    @(negedge clk);
    rx_req = 1'b0;
    chk("R8", "rx_busy after request", rx_busy, 1);
    slv_pull = !d[7];
    prev = !scl_pull;
    forever begin
      @(negedge clk);
      buf_we = 1'b0;
      guard++;
      line = !scl_pull;
      if (line && !prev) begin
        rises++;
        if (rises == 3 && coll) begin buf_we = 1'b1; buf_wdata = ~d; end
      end
      if (!line && prev) begin
        falls++;
        slv_pull = (falls < 8) ? !d[7-falls] : 1'b0;
      end
      prev = line;
      if (irq || guard > 4000) break;
    end
    buf_we = 1'b0; slv_pull = 1'b0;
    if (exp_bf) exp_ovf = 1'b1;
    else exp_buf = d;
    exp_bf = 1'b1;
    chk("R8", "buffer after receive", buf_rdata, exp_buf);
    chk("R8", "buf_full after receive", buf_full, 1);
    chk("R8", "rx_busy cleared", rx_busy, 0);
    chk("R10", "overflow flag", rx_ovf, exp_ovf);
    if (coll) begin
      chk("R7", "wr_coll during receive", wr_coll, 1);
      pulse_clr(1);
    end
    pulse_clr(0);
    if (rd) begin
      @(negedge clk); buf_re = 1'b1;
      @(negedge clk); buf_re = 1'b0;
      exp_bf = 1'b0;
      chk("R9", "buf_full after read", buf_full, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h0000_5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "scl_pull", scl_pull, 0);
    chk("R1", "sda_pull", sda_pull, 0);
    chk("R1", "flags", {buf_full, wr_coll, rx_ovf, ack_nack, irq, rx_busy}, 0);
    chk("R1", "buffer", buf_rdata, 0);

    tx_byte(8'hA5, 1'b1, 2, 1'b0, 1'b0, 1'b0);
    tx_byte(8'h3C, 1'b0, 0, 1'b0, 1'b0, 1'b0);
    tx_byte(8'h81, 1'b1, 3, 1'b1, 1'b0, 1'b0);
    tx_byte(8'h7E, 1'b1, 1, 1'b0, 1'b1, 1'b0);
    tx_byte(8'h00, 1'b0, 1, 1'b0, 1'b0, 1'b1);
    rx_byte(8'hC3, 1, 1'b0, 1'b0);
    rx_byte(8'h5A, 2, 1'b1, 1'b0);
    chk("R10", "old byte kept on overflow", buf_rdata, 8'hC3);
    pulse_clr(2);
    exp_ovf = 1'b0;
    chk("R10", "overflow cleared", rx_ovf, 0);
    rx_byte(8'h96, 0, 1'b1, 1'b1);

    for (int i = 0; i < 16; i++) begin
      logic [7:0] d;
      int rl;
      d  = 8'($urandom);
      rl = int'($urandom % 4);
      if ($urandom % 2 == 0) begin
        tx_byte(d, 1'($urandom), rl, 1'b0, 1'b0, 1'b0);
      end else begin
        rx_byte(d, rl, 1'($urandom), 1'b0);
        if (exp_ovf && ($urandom % 2 == 0)) begin
          pulse_clr(2);
          exp_ovf = 1'b0;
          chk("R10", "overflow cleared", rx_ovf, 0);
        end
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule